// File: doc/BRIEF.md
# Coincidence-Started Multichannel Interval Timer

The block times up to 32 event channels against one shared start instant. While it sits idle it watches all event inputs each clock; as soon as enough of them are high in the same cycle, every channel timer clears and starts counting on that edge. Each timer then stops on its own input and keeps its count. A stop input is ignored during a blanking window that opens at the start. This stops the inputs that caused the start from ending their own measurement. A timer that never sees a stop input counts up to full scale and stops there.

Once every timer has stopped, a ready flag is raised and the whole set of counts can be read by an SPI master as one 512-bit frame on a serial data output. Chip-select and the serial clock are synchronised into the system clock and their edges are found by comparing samples. When chip-select rises at the end of the read, the block returns to idle and waits for the next start. The output enable for the serial data pin is a separate port, and the pad driver sits outside the block.

Top module: `itm_top`

## Requirements
- R1: While reset is low and after reset is released, ready is low and the serial data output enable is low. Every timer starts stopped at zero.
- R2: In the idle state, a start happens on the first enabled clock edge at which at least START_MIN (4) event inputs are high together. Three high inputs, however long they stay, do not start it. On the start edge all timers clear to zero and begin counting.
- R3: Call the start edge edge 0. A running timer adds one on each later enabled edge. On the first enabled edge k after the blanking window at which its own input is high, it stops and keeps the value k-1.
- R4: A timer that reaches 16'hFFFF stops there. A stop input that arrives on the edge where it is already at 16'hFFFF also leaves 16'hFFFF. A stop one edge earlier leaves 16'hFFFE.
- R5: Stop inputs are ignored on the first BLANK_CYC enabled edges after the start edge. An input held high from the start therefore reads BLANK_CYC.
- R6: Ready rises on the enabled edge after the one where the last timer stops. It stays high only while the block waits for the read. During that wait and during the read, the event inputs have no effect on the timer values.
- R7: A falling chip-select in the waiting state starts the read and drops ready. A rising chip-select during the read returns the block to idle, and it can then be started again.
- R8: The frame is 512 bits. Timer 0 goes out first, and each 16-bit value goes out most significant bit first. The first bit is on the data output before the first SCK rise, and each detected SCK rise presents the next bit.
- R9: The data output enable is high only while reset is high, enable is high and chip-select is low.
- R10: If chip-select is low outside the waiting and reading states, the data output reads one on every SCK rise and the control state does not change.
- R11: While enable is low, timers, the blanking count and the control state all hold. Cycles with enable low do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low freezes all state |
| ev_in | input | 32 | Event inputs, synchronous to clk; bit i is channel i |
| cs_n | input | 1 | SPI chip-select, active low, asynchronous |
| sck | input | 1 | SPI serial clock, asynchronous |
| miso | output | 1 | Serial frame data |
| miso_oe | output | 1 | Output enable for the serial data pad |
| ready | output | 1 | High while the counts wait to be read |

## Verification
A channel's own stop input can land on the very edge where that timer reaches full scale, so the stop path and the saturation path act in the same cycle. The bench aims stop inputs at that edge and at the edge before it in a long run, and expects 16'hFFFF and 16'hFFFE in the frame. Stop pulses are also placed inside the blanking window and exactly on its first open edge. Enable is dropped at random during counting, and every count is compared with a bench model that only advances on enabled edges.

// File: rtl/itm_pkg.sv
package itm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_READ  = 2'd3
  } itm_state_e;

endpackage

// File: rtl/itm_sync.sv
module itm_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);

  logic [W-1:0] s1;

  // two flops for metastability, a third holds the previous sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= RST_VAL;
      lvl  <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      s1   <= d;
      lvl  <= s1;
      prev <= lvl;
    end
  end

endmodule

// File: rtl/itm_arm.sv
module itm_arm
  import itm_pkg::*;
#(
  parameter int N_CH      = 32,
  parameter int START_MIN = 4,
  parameter int BLANK_CYC = 21844
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  itm_state_e      state,
  input  logic [N_CH-1:0] ev,
  output logic            start_fire,
  output logic            blank_open
);

  localparam int CW = $clog2(N_CH + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);

  function automatic logic [CW-1:0] ones(input logic [N_CH-1:0] v);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_CH; i++) acc = acc + CW'(v[i]);
    return acc;
  endfunction

  logic [CW-1:0] hits;
  logic [BW-1:0] blank_cnt;

  assign hits       = ones(ev);
  assign start_fire = en && (state == ST_IDLE) && (hits >= CW'(START_MIN));
  assign blank_open = (blank_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
    end else if (en) begin
      if (start_fire)
        blank_cnt <= BW'(BLANK_CYC);
      else if (state == ST_COUNT && !blank_open)
        blank_cnt <= blank_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/itm_timer_bank.sv
module itm_timer_bank #(
  parameter int N_CH = 32,
  parameter int TW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               start_fire,
  input  logic               stop_window,
  input  logic [N_CH-1:0]    ev,
  output logic [N_CH*TW-1:0] vals,
  output logic [N_CH-1:0]    run
);

  localparam logic [TW-1:0] FULL = {TW{1'b1}};

  function automatic logic at_full(input logic [TW-1:0] v);
    return v == FULL;
  endfunction

  for (genvar g = 0; g < N_CH; g++) begin : g_tmr
    logic [TW-1:0] v;

    // R1: each timer resets stopped at zero
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v      <= '0;
        run[g] <= 1'b0;
      end else if (en) begin
        if (start_fire) begin
          v      <= '0;
          run[g] <= 1'b1;
        end else if (run[g]) begin
          if (stop_window && ev[g])
            run[g] <= 1'b0;
          else if (at_full(v))
            run[g] <= 1'b0;
          else
            v <= v + 1'b1;
        end
      end
    end

    assign vals[g*TW +: TW] = v;
  end

endmodule

// File: rtl/itm_ctrl.sv
module itm_ctrl
  import itm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start_fire,
  input  logic       all_stopped,
  input  logic       cs_fall,
  input  logic       cs_rise,
  output itm_state_e state
);

  itm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start_fire)  nxt = ST_COUNT;
      ST_COUNT: if (all_stopped) nxt = ST_WAIT;
      ST_WAIT:  if (cs_fall)     nxt = ST_READ;
      ST_READ:  if (cs_rise)     nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state <= ST_IDLE;
    else if (en) state <= nxt;
  end

endmodule

// File: rtl/itm_spi_out.sv
module itm_spi_out
  import itm_pkg::*;
#(
  parameter int FRAME = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  itm_state_e       state,
  input  logic             cs_lvl,
  input  logic             sck_rise,
  input  logic [FRAME-1:0] frame,
  output logic             bit_q
);

  localparam int FW = $clog2(FRAME);

  logic [FW-1:0] idx;
  logic [FW-1:0] idx_dn;
  logic          spent;

  assign idx_dn = idx - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= FW'(FRAME - 1);
      spent <= 1'b0;
      bit_q <= 1'b1;
    end else if (en) begin
      if (cs_lvl) begin
        idx   <= FW'(FRAME - 1);
        spent <= 1'b0;
        bit_q <= (state == ST_WAIT) ? frame[FRAME-1] : 1'b1;
      end else if (sck_rise) begin
        if (state == ST_READ && !spent) begin
          if (idx == '0) begin
            spent <= 1'b1;
            bit_q <= 1'b1;
          end else begin
            idx   <= idx_dn;
            bit_q <= frame[idx_dn];
          end
        end else begin
          bit_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/itm_top.sv
module itm_top
  import itm_pkg::*;
#(
  parameter int N_CH      = 32,
  parameter int TW        = 16,
  parameter int START_MIN = 4,
  parameter int BLANK_CYC = 21844
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [N_CH-1:0] ev_in,
  input  logic            cs_n,
  input  logic            sck,
  output logic            miso,
  output logic            miso_oe,
  output logic            ready
);

  localparam int FRAME = N_CH * TW;

  // named internal events, also seen by the checker
  itm_state_e         state;
  logic               start_fire;
  logic               blank_open;
  logic               stop_window;
  logic               all_stopped;
  logic [N_CH-1:0]    run;
  logic [FRAME-1:0]   vals;
  logic [FRAME-1:0]   frame;
  logic [1:0]         spi_lvl;
  logic [1:0]         spi_prev;
  logic               cs_lvl;
  logic               cs_fall;
  logic               cs_rise;
  logic               sck_rise;
  logic               bit_q;

  itm_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, sck}),
    .lvl  (spi_lvl),
    .prev (spi_prev)
  );

  assign cs_lvl   = spi_lvl[1];
  assign cs_fall  = spi_prev[1] && !spi_lvl[1];
  assign cs_rise  = !spi_prev[1] && spi_lvl[1];
  assign sck_rise = !spi_prev[0] && spi_lvl[0];

  itm_arm #(.N_CH(N_CH), .START_MIN(START_MIN), .BLANK_CYC(BLANK_CYC)) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .state     (state),
    .ev        (ev_in),
    .start_fire(start_fire),
    .blank_open(blank_open)
  );

  assign stop_window = (state == ST_COUNT) && blank_open;

  itm_timer_bank #(.N_CH(N_CH), .TW(TW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .start_fire (start_fire),
    .stop_window(stop_window),
    .ev         (ev_in),
    .vals       (vals),
    .run        (run)
  );

  assign all_stopped = (run == '0);

  itm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .start_fire (start_fire),
    .all_stopped(all_stopped),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .state      (state)
  );

  // timer 0 occupies the top of the frame so it leaves first
  for (genvar g = 0; g < N_CH; g++) begin : g_frame
    assign frame[(N_CH-1-g)*TW +: TW] = vals[g*TW +: TW];
  end

  itm_spi_out #(.FRAME(FRAME)) u_spi (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .state   (state),
    .cs_lvl  (cs_lvl),
    .sck_rise(sck_rise),
    .frame   (frame),
    .bit_q   (bit_q)
  );

  assign ready   = (state == ST_WAIT);
  assign miso    = bit_q;
  assign miso_oe = rst_n && en && !cs_n;

endmodule

// File: rtl/itm_top_chk.sv
module itm_top_chk
  import itm_pkg::*;
#(
  parameter int N_CH = 32,
  parameter int TW   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               cs_n,
  input logic               miso_oe,
  input logic               ready,
  input itm_state_e         state,
  input logic               start_fire,
  input logic               blank_open,
  input logic [N_CH-1:0]    run,
  input logic [N_CH*TW-1:0] vals
);

  logic [N_CH-1:0] at_full;
  always_comb begin
    for (int i = 0; i < N_CH; i++) at_full[i] = (vals[i*TW +: TW] == {TW{1'b1}});
  end

  // R2: start clears every timer and sets all running
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> ((run == '1) && (vals == '0)));

  // R4: a running timer seen at full scale is stopped after the edge
  a_r4_full_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_COUNT) |=> ((run & $past(at_full & run)) == '0));

  // R5: no timer stops while the blanking window is closed
  a_r5_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_COUNT && !blank_open) |=> (run == $past(run)));

  // R6: ready only with all timers stopped
  a_r6_ready_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (run == '0));

  // R6: counts frozen while waiting or reading
  a_r6_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT || state == ST_READ) |=> $stable(vals));

  // R7: ready only leaves toward the read state
  a_r7_ready_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (state == ST_READ));

  // R9: the pad is never driven with chip-select high or the block disabled
  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !en) |-> !miso_oe);

endmodule

bind itm_top itm_top_chk #(.N_CH(N_CH), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .cs_n      (cs_n),
  .miso_oe   (miso_oe),
  .ready     (ready),
  .state     (state),
  .start_fire(start_fire),
  .blank_open(blank_open),
  .run       (run),
  .vals      (vals)
);

// File: tb/tb_itm_top.sv
`timescale 1ns/1ps
module tb_itm_top;
  localparam int N     = 32;
  localparam int TW    = 16;
  localparam int BLANK = 40;
  localparam int FULL  = (1 << TW) - 1;
  localparam int NEVER = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cs_n = 1'b1, sck = 1'b0;
  logic [N-1:0] ev = '0;
  logic miso, miso_oe, ready;

  int n_chk = 0, n_bad = 0;
  int mval[N];
  bit mrun[N];
  int mblank;
  int stop_at[N];
  int noise_at[N];
  int unsigned seed_v;

  always #2.5 clk = ~clk;

  itm_top #(.N_CH(N), .TW(TW), .START_MIN(4), .BLANK_CYC(BLANK)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ev_in(ev), .cs_n(cs_n), .sck(sck),
    .miso(miso), .miso_oe(miso_oe), .ready(ready));

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of one enabled edge, from R3 R4 R5 R11
  task automatic model_edge(logic [N-1:0] e, bit en_now);
    if (!en_now) return;
    for (int i = 0; i < N; i++) begin
      if (mrun[i]) begin
        if (e[i] && mblank == 0) mrun[i] = 0;
        else if (mval[i] == FULL) mrun[i] = 0;
        else mval[i]++;
      end
    end
    if (mblank > 0) mblank--;
  endtask

  function automatic bit any_running();
    for (int i = 0; i < N; i++) if (mrun[i]) return 1;
    return 0;
  endfunction

  task automatic random_stops(int span);
    for (int i = 0; i < N; i++) begin
      stop_at[i]  = $urandom_range(1, BLANK + span);
      noise_at[i] = ($urandom_range(0, 1) == 1) ? $urandom_range(1, BLANK) : 0;
    end
  endtask

  task automatic run_round(logic [N-1:0] start_pat, logic [N-1:0] pre_pat,
                           int pre_cycles, bit gaps);
    int k;
    logic [N-1:0] e;
    bit en_now;
    en = 1'b1;
    if (pre_cycles > 0) begin
      ev = pre_pat;
      clks(pre_cycles);
      check("R2", ready, 0, "three inputs must not start");
    end
    ev = start_pat;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin mval[i] = 0; mrun[i] = 1; end
    mblank = BLANK;
    k = 0;
    while (any_running()) begin
      k++;
      e = '0;
      for (int i = 0; i < N; i++) if (k >= stop_at[i] || k == noise_at[i]) e[i] = 1'b1;
      en_now = gaps ? ($urandom_range(0, 9) != 0) : 1'b1;
      ev = e;
      en = en_now;
      @(negedge clk);
      model_edge(e, en_now);
    end
    en = 1'b1;
    check("R6", ready, 0, "ready on the edge of the last stop");
    ev = '1;
    @(negedge clk);
    check("R6", ready, 1, "ready one edge after the last stop");
    clks(5);
    check("R6", ready, 1, "ready held while inputs all high");
  endtask

  task automatic read_frame(string tag, bit en_blip);
    logic [N*TW-1:0] got;
    check("R9", miso_oe, 0, "no drive before chip-select");
    cs_n = 1'b0;
    clks(6);
    check("R7", ready, 0, "ready drops when read starts");
    check("R9", miso_oe, 1, "drive during read");
    got[N*TW-1] = miso;
    for (int b = N*TW-2; b >= 0; b--) begin
      sck = 1'b1;
      clks(5);
      got[b] = miso;
      clks(1);
      sck = 1'b0;
      clks(6);
      if (en_blip && b == 300) begin
        en = 1'b0;
        clks(1);
        check("R9", miso_oe, 0, "no drive while disabled");
        clks(3);
        en = 1'b1;
        clks(1);
      end
    end
    for (int t = 0; t < N; t++)
      check($sformatf("R8 %s ch%0d", tag, t), int'(got[(N-1-t)*TW +: TW]), mval[t], "timer value");
    ev = '0;
    cs_n = 1'b1;
    clks(6);
    check("R9", miso_oe, 0, "no drive after chip-select rises");
    check("R7", ready, 0, "idle after chip-select rises");
  endtask

  task automatic idle_cs_probe();
    cs_n = 1'b0;
    clks(6);
    check("R10", miso_oe, 1, "drive with chip-select low in idle");
    for (int j = 0; j < 3; j++) begin
      sck = 1'b1; clks(5);
      check("R10", miso, 1, "ones outside read");
      clks(1); sck = 1'b0; clks(6);
    end
    check("R10", ready, 0, "state unchanged");
    cs_n = 1'b1;
    clks(6);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [N-1:0] pat;
    seed_v = $urandom(32'h5A17C3E1);
    clks(4);
    check("R1", ready, 0, "ready in reset");
    check("R1", miso_oe, 0, "no drive in reset");
    rst_n = 1'b1;
    clks(3);
    en = 1'b1;
    clks(1);
    check("R1", ready, 0, "ready after reset");
    check("R9", miso_oe, 0, "no drive with chip-select high");

    idle_cs_probe();

    // directed: three inputs first, then a fourth; held inputs read BLANK
    random_stops(150);
    pat = '0; pat[0] = 1; pat[5] = 1; pat[9] = 1;
    for (int i = 0; i < N; i++) if (pat[i]) stop_at[i] = 1;
    stop_at[31] = 1;
    stop_at[12] = BLANK + 1; noise_at[12] = 0;
    stop_at[13] = BLANK;     noise_at[13] = BLANK;
    run_round(pat | (32'd1 << 31), pat, 20, 1'b0);
    read_frame("R2 R3 R5", 1'b0);

    // random rounds with enable gaps
    for (int r = 0; r < 3; r++) begin
      pat = '0;
      while ($countones(pat) < 4 + r) pat[$urandom_range(0, N-1)] = 1'b1;
      random_stops(200);
      run_round(pat, '0, 0, 1'b1);
      read_frame("R3 R5 R11", r == 1);
      if (r == 0) idle_cs_probe();
    end

    // saturation with stop on the full-scale edge and the edge before
    random_stops(100);
    for (int i = 0; i < 4; i++) stop_at[i] = 1;
    stop_at[4] = FULL + 1;
    stop_at[5] = FULL;
    for (int i = 6; i < 10; i++) stop_at[i] = NEVER;
    run_round(32'h0000_000F, '0, 0, 1'b0);
    check("R4", mval[4], FULL, "model stop on full edge");
    read_frame("R4", 1'b0);

    finish_run();
  end

endmodule